// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

This block is a timer that runs either as a single 16-bit counter or as two independent 8-bit counters. Either way, a counter that wraps past its all-ones value loads a programmed reload value instead of rolling over to zero. One control register sets the mode, the run state, the tick source and the low-byte interrupt enable. The same register also shows the two sticky overflow flags. Software reads these flags and clears them by writing zeros.

A count tick comes from one of two sources:
- the system clock divided by 12;
- an external clock, brought into the system clock domain through a two-flop synchroniser, turned into a one-cycle pulse on each rising edge, and divided by 8.

A single interrupt request combines the two flags under a global enable, which comes from outside the block. Each counter byte can be written directly, and the reload values for the two bytes are separate inputs.

Top module: `split_reload_timer`

## Requirements
- R1: The control register reads 0x00 after reset, and both counter bytes, both flags and the interrupt request are 0. Control bit layout: bit 0 run, bit 1 split mode, bit 2 external tick select, bit 3 low-byte interrupt enable, bit 4 low overflow flag, bit 5 high overflow flag.
- R2: With split = 0 and run = 1, the 16-bit value {high, low} advances by one on every tick. A low byte at 0xFF goes to 0x00 and carries into the high byte. With split = 0 and run = 0, neither byte changes.
- R3: With split = 0, a tick at 0xFFFF loads {reload_hi, reload_lo} and sets the high overflow flag (bit 5).
- R4: With split = 1, each byte at 0xFF loads its own reload value on a tick. The low byte counts whatever the run bit is. The high byte counts only while run = 1, and its wrap sets the high flag.
- R5: The low overflow flag (bit 4) sets whenever the low byte wraps past 0xFF, in either mode.
- R6: No hardware action clears a flag. A control write clears a flag where the written bit is 0, and leaves it unchanged where the written bit is 1.
- R7: If a flag is set by hardware and cleared by a control write in the same cycle, the flag ends up set.
- R8: irq = irq_global_en AND (high flag OR (low flag AND bit 3)).
- R9: With bit 2 = 0, ticks occur exactly once every 12 system clock cycles.
- R10: With bit 2 = 1, one tick occurs for every 8 rising edges of ext_clk.
- R11: A counter-byte write loads cnt_wdata in that cycle instead of counting that byte. No overflow occurs from that byte in that cycle.
- R12: Control bits 7:6 always read as 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External clock source, asynchronous |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register read value |
| cnt_lo_wr | input | 1 | Low counter byte write strobe |
| cnt_hi_wr | input | 1 | High counter byte write strobe |
| cnt_wdata | input | W | Counter byte write data |
| reload_lo | input | W | Reload value for the low byte |
| reload_hi | input | W | Reload value for the high byte |
| irq_global_en | input | 1 | Global enable for the interrupt request |
| cnt_lo | output | W | Low counter byte |
| cnt_hi | output | W | High counter byte |
| flag_lo | output | 1 | Low overflow flag |
| flag_hi | output | 1 | High overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a hardware overflow and a software flag clear. The second is a counter write and a count tick.

To hit both, the bench first locks onto the 12-cycle tick phase by watching the low byte change. It then preloads 0xFF into the low byte. Exactly twelve cycles after the observed tick, it issues a control write that clears the flags. The flag must still read 1 afterwards.

Twelve cycles later, on the next tick, a counter write lands on the tick edge. The written value must appear with no increment, and the high byte must stay unchanged.

// File: rtl/srt_pkg.sv
package srt_pkg;
   localparam int CTL_W     = 8;
   localparam int BIT_RUN   = 0;
   localparam int BIT_SPLIT = 1;
   localparam int BIT_EXT   = 2;
   localparam int BIT_LOIE  = 3;
   localparam int BIT_FLO   = 4;
   localparam int BIT_FHI   = 5;
   localparam int N_FLAGS   = 2;
   localparam int N_BYTES   = 2;

   typedef struct packed {
      logic lo_ie;
      logic ext_sel;
      logic split;
      logic run;
   } srt_ctl_t;

   typedef enum logic {
      SRC_SYS = 1'b0,
      SRC_EXT = 1'b1
   } srt_src_e;
endpackage

// File: rtl/srt_divider.sv
module srt_divider #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic pulse
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("srt_divider: DIV must be at least 1");
      end else if (DIV == 1) begin : g_pass
         assign pulse = en;
      end else begin : g_cnt
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (en) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end
         assign pulse = en && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/srt_tick_gen.sv
module srt_tick_gen import srt_pkg::*; #(
   parameter int SYS_DIV     = 12,
   parameter int EXT_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ext_clk,
   input  srt_src_e src_sel,
   output logic     tick
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("srt_tick_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_last_q;
   logic                   ext_rise;
   logic                   sys_tick;
   logic                   ext_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q     <= '0;
         ext_last_q <= 1'b0;
      end else begin
         sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk};
         ext_last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_last_q;

   srt_divider #(.DIV(SYS_DIV)) u_sys_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .pulse (sys_tick)
   );

   srt_divider #(.DIV(EXT_DIV)) u_ext_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ext_rise),
      .pulse (ext_tick)
   );

   assign tick = (src_sel == SRC_EXT) ? ext_tick : sys_tick;
endmodule

// File: rtl/srt_byte_counter.sv
module srt_byte_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         step,
   input  logic [W-1:0] wrap_val,
   output logic [W-1:0] q,
   output logic         at_max
);
   logic [W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (load_en) begin
         q_r <= load_val;
      end else if (step) begin
         q_r <= (&q_r) ? wrap_val : q_r + 1'b1;
      end
   end

   assign q      = q_r;
   assign at_max = &q_r;
endmodule

// File: rtl/srt_flag_bit.sv
module srt_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_wr,
   input  logic sw_val,
   output logic flag
);
   logic flag_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_r <= 1'b0;
      end else if (hw_set) begin
         flag_r <= 1'b1;
      end else if (sw_wr && !sw_val) begin
         flag_r <= 1'b0;
      end
   end

   assign flag = flag_r;
endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer import srt_pkg::*; #(
   parameter int W           = 8,
   parameter int SYS_DIV     = 12,
   parameter int EXT_DIV     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cnt_lo_wr,
   input  logic             cnt_hi_wr,
   input  logic [W-1:0]     cnt_wdata,
   input  logic [W-1:0]     reload_lo,
   input  logic [W-1:0]     reload_hi,
   input  logic             irq_global_en,
   output logic [W-1:0]     cnt_lo,
   output logic [W-1:0]     cnt_hi,
   output logic             flag_lo,
   output logic             flag_hi,
   output logic             irq
);
   generate
      if (W < 2) begin : g_bad_w
         $error("split_reload_timer: W must be at least 2");
      end
      if (SYS_DIV < 2) begin : g_bad_sys
         $error("split_reload_timer: SYS_DIV must be at least 2");
      end
      if (EXT_DIV < 2) begin : g_bad_ext
         $error("split_reload_timer: EXT_DIV must be at least 2");
      end
      if (CTL_W < BIT_FHI + 1) begin : g_bad_ctl
         $error("split_reload_timer: control word too narrow");
      end
   endgenerate

   srt_ctl_t ctl_q;
   logic     tick;
   logic     lo_step, hi_step, lo_wrap, hi_wrap;
   logic [W-1:0] lo_wrap_val;

   logic [N_BYTES-1:0] byte_wr, byte_step, byte_max;
   logic [W-1:0]       byte_wrap_val [N_BYTES];
   logic [W-1:0]       byte_q        [N_BYTES];
   logic [N_FLAGS-1:0] flag_set, flag_wbit, flag_v;
   logic               wdata_unused;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_wr) begin
         ctl_q.run     <= ctl_wdata[BIT_RUN];
         ctl_q.split   <= ctl_wdata[BIT_SPLIT];
         ctl_q.ext_sel <= ctl_wdata[BIT_EXT];
         ctl_q.lo_ie   <= ctl_wdata[BIT_LOIE];
      end
   end

   assign wdata_unused = ^ctl_wdata[CTL_W-1:BIT_FHI+1];

   srt_tick_gen #(
      .SYS_DIV     (SYS_DIV),
      .EXT_DIV     (EXT_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ext_clk),
      .src_sel (srt_src_e'(ctl_q.ext_sel)),
      .tick    (tick)
   );

   // Count enables: low byte free-runs in split mode, high byte is
   // gated by run in both modes and chained on the low wrap otherwise.
   always_comb begin
      lo_step     = tick & (ctl_q.split | ctl_q.run) & ~cnt_lo_wr;
      lo_wrap     = lo_step & byte_max[0];
      hi_step     = tick & ctl_q.run & (ctl_q.split | lo_wrap) & ~cnt_hi_wr;
      hi_wrap     = hi_step & byte_max[1];
      lo_wrap_val = (ctl_q.split | hi_wrap) ? reload_lo : '0;
   end

   assign byte_wr          = {cnt_hi_wr, cnt_lo_wr};
   assign byte_step        = {hi_step, lo_step};
   assign byte_wrap_val[0] = lo_wrap_val;
   assign byte_wrap_val[1] = reload_hi;

   generate
      for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
         srt_byte_counter #(.W(W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (byte_wr[b]),
            .load_val (cnt_wdata),
            .step     (byte_step[b]),
            .wrap_val (byte_wrap_val[b]),
            .q        (byte_q[b]),
            .at_max   (byte_max[b])
         );
      end
   endgenerate

   assign flag_set  = {hi_wrap, lo_wrap};
   assign flag_wbit = {ctl_wdata[BIT_FHI], ctl_wdata[BIT_FLO]};

   generate
      for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
         srt_flag_bit u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (flag_set[f]),
            .sw_wr  (ctl_wr),
            .sw_val (flag_wbit[f]),
            .flag   (flag_v[f])
         );
      end
   endgenerate

   always_comb begin
      ctl_rdata            = '0;
      ctl_rdata[BIT_RUN]   = ctl_q.run;
      ctl_rdata[BIT_SPLIT] = ctl_q.split;
      ctl_rdata[BIT_EXT]   = ctl_q.ext_sel;
      ctl_rdata[BIT_LOIE]  = ctl_q.lo_ie;
      ctl_rdata[BIT_FLO]   = flag_v[0];
      ctl_rdata[BIT_FHI]   = flag_v[1];
   end

   assign cnt_lo  = byte_q[0];
   assign cnt_hi  = byte_q[1];
   assign flag_lo = flag_v[0];
   assign flag_hi = flag_v[1];
   assign irq     = irq_global_en & (flag_v[1] | (flag_v[0] & ctl_q.lo_ie));
endmodule

// File: rtl/srt_checker.sv
module srt_checker import srt_pkg::*; #(
   parameter int W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_wr,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic [CTL_W-1:0] ctl_rdata,
   input logic             cnt_lo_wr,
   input logic             cnt_hi_wr,
   input logic [W-1:0]     cnt_wdata,
   input logic             irq_global_en,
   input logic [W-1:0]     cnt_lo,
   input logic [W-1:0]     cnt_hi,
   input logic             flag_lo,
   input logic             flag_hi,
   input logic             irq
);
   // R6
   flag_lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_lo && !(ctl_wr && !ctl_wdata[BIT_FLO])) |=> flag_lo);

   // R6
   flag_hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_hi && !(ctl_wr && !ctl_wdata[BIT_FHI])) |=> flag_hi);

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_global_en |-> !irq);

   // R8
   irq_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_global_en && flag_hi) |-> irq);

   // R11
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_lo_wr |=> (cnt_lo == $past(cnt_wdata)));

   // R11
   hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_hi_wr |=> (cnt_hi == $past(cnt_wdata)));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[BIT_RUN] && !ctl_rdata[BIT_SPLIT] && !cnt_lo_wr && !cnt_hi_wr)
      |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   // R5
   flo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_lo) |-> ($past(cnt_lo) == {W{1'b1}}));

   // R3
   fhi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_hi) |-> ($past(cnt_hi) == {W{1'b1}}));
endmodule

bind split_reload_timer srt_checker #(.W(W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl_wr        (ctl_wr),
   .ctl_wdata     (ctl_wdata),
   .ctl_rdata     (ctl_rdata),
   .cnt_lo_wr     (cnt_lo_wr),
   .cnt_hi_wr     (cnt_hi_wr),
   .cnt_wdata     (cnt_wdata),
   .irq_global_en (irq_global_en),
   .cnt_lo        (cnt_lo),
   .cnt_hi        (cnt_hi),
   .flag_lo       (flag_lo),
   .flag_hi       (flag_hi),
   .irq           (irq)
);

// File: tb/split_reload_timer_tb.sv
module split_reload_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ext_clk;
   logic       ctl_wr;
   logic [7:0] ctl_wdata;
   logic [7:0] ctl_rdata;
   logic       cnt_lo_wr;
   logic       cnt_hi_wr;
   logic [7:0] cnt_wdata;
   logic [7:0] reload_lo;
   logic [7:0] reload_hi;
   logic       irq_global_en;
   logic [7:0] cnt_lo;
   logic [7:0] cnt_hi;
   logic       flag_lo;
   logic       flag_hi;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4ns clk = ~clk;

   split_reload_timer dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .ext_clk       (ext_clk),
      .ctl_wr        (ctl_wr),
      .ctl_wdata     (ctl_wdata),
      .ctl_rdata     (ctl_rdata),
      .cnt_lo_wr     (cnt_lo_wr),
      .cnt_hi_wr     (cnt_hi_wr),
      .cnt_wdata     (cnt_wdata),
      .reload_lo     (reload_lo),
      .reload_hi     (reload_hi),
      .irq_global_en (irq_global_en),
      .cnt_lo        (cnt_lo),
      .cnt_hi        (cnt_hi),
      .flag_lo       (flag_lo),
      .flag_hi       (flag_hi),
      .irq           (irq)
   );

   typedef struct packed {
      logic [7:0] ctl;
      logic [7:0] lo;
      logic [7:0] hi;
      logic [7:0] rl_lo;
      logic [7:0] rl_hi;
      logic       gen;
      logic [7:0] nt;
      logic [7:0] e_lo;
      logic [7:0] e_hi;
      logic       e_flo;
      logic       e_fhi;
      logic       e_irq;
   } vec_t;

   // ctl bits: 0 run, 1 split, 2 ext, 3 low irq enable
   localparam vec_t VECS [5] = '{
      '{8'h09, 8'hFE, 8'h00, 8'h00, 8'h00, 1'b1, 8'd3, 8'h01, 8'h01, 1'b1, 1'b0, 1'b1},
      '{8'h01, 8'hFE, 8'hFF, 8'h34, 8'h12, 1'b0, 8'd3, 8'h35, 8'h12, 1'b1, 1'b1, 1'b0},
      '{8'h03, 8'hFF, 8'hFE, 8'h80, 8'h40, 1'b1, 8'd3, 8'h82, 8'h41, 1'b1, 1'b1, 1'b1},
      '{8'h02, 8'hFE, 8'h10, 8'h05, 8'h00, 1'b1, 8'd4, 8'h07, 8'h10, 1'b1, 1'b0, 1'b0},
      '{8'h08, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b1, 8'd5, 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk);
      ctl_wr    = 1'b1;
      ctl_wdata = d;
      @(posedge clk);
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_lo(input logic [7:0] d);
      @(negedge clk);
      cnt_lo_wr = 1'b1;
      cnt_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cnt_lo_wr = 1'b0;
   endtask

   task automatic wr_hi(input logic [7:0] d);
      @(negedge clk);
      cnt_hi_wr = 1'b1;
      cnt_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cnt_hi_wr = 1'b0;
   endtask

   task automatic ext_pulses(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ext_clk = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk = 1'b0;
         repeat (2) @(negedge clk);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      vec_t v;
      rst_n = 1'b0;
      ext_clk = 1'b0;
      ctl_wr = 1'b0;
      ctl_wdata = '0;
      cnt_lo_wr = 1'b0;
      cnt_hi_wr = 1'b0;
      cnt_wdata = '0;
      reload_lo = '0;
      reload_hi = '0;
      irq_global_en = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 ctl", ctl_rdata, 8'h00);
      chk("R1 lo", cnt_lo, 8'h00);
      chk("R1 hi", cnt_hi, 8'h00);
      chk("R1 flags/irq", {flag_hi, flag_lo, irq}, 3'b000);

      // Table of timed runs: exactly nt ticks fall in a 12*nt window (R9)
      for (int i = 0; i < 5; i++) begin
         v = VECS[i];
         irq_global_en = v.gen;
         reload_lo = v.rl_lo;
         reload_hi = v.rl_hi;
         wr_ctl(8'h00);
         wr_lo(v.lo);
         wr_hi(v.hi);
         wr_ctl(v.ctl | 8'h30);
         repeat (12 * int'(v.nt) - 1) @(posedge clk);
         wr_ctl(8'hF0 | (v.ctl & 8'h08));
         chk("R2 R3 R4 R9 lo byte", cnt_lo, v.e_lo);
         chk("R2 R3 R4 R9 hi byte", cnt_hi, v.e_hi);
         chk("R3 R4 R5 R6 flags", {flag_hi, flag_lo}, {v.e_fhi, v.e_flo});
         chk("R8 irq", irq, v.e_irq);
         chk("R12 unused bits", ctl_rdata[7:6], 2'b00);
      end

      // Phase-locked corner cases: R7 and R11
      irq_global_en = 1'b0;
      reload_lo = 8'h00;
      reload_hi = 8'h00;
      wr_ctl(8'h00);
      wr_lo(8'h00);
      wr_hi(8'h00);
      wr_ctl(8'h01);
      while (cnt_lo == 8'h00) @(negedge clk);
      cnt_lo_wr = 1'b1;
      cnt_wdata = 8'hFF;
      @(posedge clk);
      @(negedge clk);
      cnt_lo_wr = 1'b0;
      repeat (10) @(posedge clk);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = 8'h01;
      @(posedge clk);
      @(negedge clk);
      ctl_wr = 1'b0;
      chk("R7 set beats clear", flag_lo, 1'b1);
      chk("R2 R5 carry lo", cnt_lo, 8'h00);
      chk("R2 carry hi", cnt_hi, 8'h01);
      repeat (11) @(posedge clk);
      @(negedge clk);
      cnt_lo_wr = 1'b1;
      cnt_wdata = 8'h55;
      @(posedge clk);
      @(negedge clk);
      cnt_lo_wr = 1'b0;
      chk("R11 write over tick lo", cnt_lo, 8'h55);
      chk("R11 write over tick hi", cnt_hi, 8'h01);

      // R6: write 1 keeps, write 0 clears
      wr_ctl(8'h30);
      chk("R6 write one keeps", {flag_hi, flag_lo}, 2'b01);
      wr_ctl(8'h00);
      chk("R6 write zero clears", {flag_hi, flag_lo}, 2'b00);
      chk("R12 ctl after zero", ctl_rdata, 8'h00);

      // R10: external tick source, divide by 8
      wr_lo(8'hFD);
      wr_hi(8'h00);
      wr_ctl(8'h05);
      ext_pulses(24);
      chk("R10 ext lo", cnt_lo, 8'h00);
      chk("R10 ext hi", cnt_hi, 8'h01);
      chk("R10 R5 ext flag", flag_lo, 1'b1);
      ext_pulses(7);
      chk("R10 seven edges no tick", cnt_lo, 8'h00);
      ext_pulses(1);
      chk("R10 eighth edge ticks", cnt_lo, 8'h01);
      wr_ctl(8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule